// File: doc/BRIEF.md
# In-band XON/XOFF flow controller

This block adds automatic software flow control to one serial channel. It has two independent halves. The generator watches the receive buffer fill level. When the level reaches a high threshold it asks the local transmitter to insert stop characters. Once the level has fallen back to a low threshold it asks for resume characters. The recogniser watches the received byte stream for programmed stop and resume characters and pauses or releases the local transmitter. It also removes those characters from the stream that goes on to the receive buffer.

Two character pairs are programmed, A and B. A 4-bit mode field picks, separately for generation (bits [3:2]) and recognition (bits [1:0]), pair A, pair B, both, or neither. When special-character detection is enabled, pair B is reserved for that purpose and never takes part in flow control. The transmitter honours a pause only between characters, so a character already in flight always completes.

Top module: `xonxoff_flow_ctl`

## Requirements
- R1: Generation uses mode bits [3:2]. Bit 3 selects pair A and bit 2 selects pair B. With both set, the stop characters go out in the order A then B, and the resume characters also go out in the order A then B.
- R2: Recognition uses mode bits [1:0]. Bit 1 selects pair A and bit 0 selects pair B. Only the selected characters affect the pause state.
- R3: A recognised stop character requests a pause and a recognised resume character withdraws it. If one byte matches both, stop wins. A pause request is dropped while no pair is selected for recognition.
- R4: `tx_hold` changes only on a clock edge where `tx_busy` is low. It then takes the current pause request.
- R5: With `fc_en` low, or with mode 0000, no character is injected, `tx_hold` stays low, and every received byte is forwarded.
- R6: With `spec_det_en` high, pair B is neither generated nor recognised, and pair B bytes are forwarded unchanged.
- R7: Stop characters are sent once per rise of `fifo_lvl` to `lvl_hi` or above. Resume characters are sent only after a stop was sent and the level is at or below `lvl_lo`.
- R8: `inj_req` stays high with `inj_chr` stable until a cycle with `inj_ack` high. Exactly one character is consumed per acknowledged cycle.
- R9: A received byte that matches a recognised character is not forwarded. Any other byte appears on `rx_fwd_byte` with `rx_fwd_vld` in the same cycle.
- R10: Synchronous active-low reset clears the pause, the stop-sent state and any pending injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fc_en | input | 1 | Software flow control enable |
| fc_mode | input | 4 | [3:2] generation pairs, [1:0] recognition pairs |
| spec_det_en | input | 1 | Reserves pair B for special-character use |
| chr_on_a | input | 8 | Resume character, pair A |
| chr_off_a | input | 8 | Stop character, pair A |
| chr_on_b | input | 8 | Resume character, pair B |
| chr_off_b | input | 8 | Stop character, pair B |
| rx_vld | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_fwd_vld | output | 1 | Byte forwarded to the receive buffer |
| rx_fwd_byte | output | 8 | Forwarded byte |
| fifo_lvl | input | LVL_W | Receive buffer fill level |
| lvl_hi | input | LVL_W | Level that triggers stop characters |
| lvl_lo | input | LVL_W | Level that allows resume characters |
| inj_req | output | 1 | Request to insert a character into the transmitter |
| inj_chr | output | 8 | Character to insert |
| inj_ack | input | 1 | Transmitter accepts `inj_chr` |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_hold | output | 1 | Transmitter must not start a new character |

## Verification
The bench builds the block with LVL_W=5, so a 0..31 level ramp crosses thresholds 24 and 8 many times per configuration. That exercises repeated stop/resume cycles and the once-per-crossing rule. All 16 mode values are swept with the enable and the special-detection flag in every combination. Randomised acknowledge and busy patterns stretch the handshakes and delay the pause. A cycle model that uses a character queue predicts the injections, the forwarded stream and the hold output on every clock.

// File: rtl/xonxoff_flow_ctl.sv
module xonxoff_flow_ctl #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fc_en,
  input  logic [3:0]       fc_mode,
  input  logic             spec_det_en,
  input  logic [7:0]       chr_on_a,
  input  logic [7:0]       chr_off_a,
  input  logic [7:0]       chr_on_b,
  input  logic [7:0]       chr_off_b,
  input  logic             rx_vld,
  input  logic [7:0]       rx_byte,
  output logic             rx_fwd_vld,
  output logic [7:0]       rx_fwd_byte,
  input  logic [LVL_W-1:0] fifo_lvl,
  input  logic [LVL_W-1:0] lvl_hi,
  input  logic [LVL_W-1:0] lvl_lo,
  output logic             inj_req,
  output logic [7:0]       inj_chr,
  input  logic             inj_ack,
  input  logic             tx_busy,
  output logic             tx_hold
);

  typedef enum logic [2:0] {S_IDLE, S_OFF_A, S_OFF_B, S_ON_A, S_ON_B} gen_st_t;

  gen_st_t st;
  logic    xoff_sent;
  logic    pause_req;

  wire gen_a = fc_en & fc_mode[3];
  wire gen_b = fc_en & fc_mode[2] & ~spec_det_en;
  wire rec_a = fc_en & fc_mode[1];
  wire rec_b = fc_en & fc_mode[0] & ~spec_det_en;

  wire hit_off = rx_vld & ((rec_a & (rx_byte == chr_off_a)) | (rec_b & (rx_byte == chr_off_b)));
  wire hit_on  = rx_vld & ((rec_a & (rx_byte == chr_on_a))  | (rec_b & (rx_byte == chr_on_b)));

  assign rx_fwd_vld  = rx_vld & ~hit_off & ~hit_on;
  assign rx_fwd_byte = rx_byte;

  wire start_off = (st == S_IDLE) & ~xoff_sent & (fifo_lvl >= lvl_hi) & (gen_a | gen_b);
  wire start_on  = (st == S_IDLE) &  xoff_sent & (fifo_lvl <= lvl_lo) & (gen_a | gen_b);

  assign inj_req = (st != S_IDLE);

  always_comb begin
    case (st)
      S_OFF_A: inj_chr = chr_off_a;
      S_OFF_B: inj_chr = chr_off_b;
      S_ON_A:  inj_chr = chr_on_a;
      S_ON_B:  inj_chr = chr_on_b;
      default: inj_chr = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      xoff_sent <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start_off) begin
            st        <= gen_a ? S_OFF_A : S_OFF_B;
            xoff_sent <= 1'b1;
          end else if (start_on) begin
            st        <= gen_a ? S_ON_A : S_ON_B;
            xoff_sent <= 1'b0;
          end
        end
        S_OFF_A: if (inj_ack) st <= gen_b ? S_OFF_B : S_IDLE;
        S_ON_A:  if (inj_ack) st <= gen_b ? S_ON_B  : S_IDLE;
        S_OFF_B, S_ON_B: if (inj_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_req <= 1'b0;
      tx_hold   <= 1'b0;
    end else begin
      if (hit_off)     pause_req <= 1'b1;
      else if (hit_on) pause_req <= 1'b0;
      if (!tx_busy)    tx_hold   <= pause_req & (rec_a | rec_b);
    end
  end

  // R8
  inj_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_req && !inj_ack |=> inj_req && $stable(inj_chr));

  // R4
  hold_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> $stable(tx_hold));

  // R9
  fwd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fwd_vld |-> rx_vld);

  // R5
  off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en && rx_vld |-> rx_fwd_vld);

  // R5
  off_noinj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |=> !$rose(inj_req));

endmodule

// File: tb/tb_xonxoff_flow_ctl.sv
module tb_xonxoff_flow_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 5;

  logic clk = 0, rst_n = 0, fc_en = 0, spec_det_en = 0;
  logic [3:0] fc_mode = 0;
  logic [7:0] chr_on_a = 8'h11, chr_off_a = 8'h13, chr_on_b = 8'h51, chr_off_b = 8'h53;
  logic rx_vld = 0; logic [7:0] rx_byte = 0;
  logic rx_fwd_vld; logic [7:0] rx_fwd_byte;
  logic [LVL_W-1:0] fifo_lvl = 0, lvl_hi = 24, lvl_lo = 8;
  logic inj_req, inj_ack = 0, tx_busy = 0, tx_hold;
  logic [7:0] inj_chr;

  xonxoff_flow_ctl #(.LVL_W(LVL_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  byte unsigned q[$];
  bit xs = 0, pend = 0, hold = 0;
  int n_offb = 0, n_holdb = 0, n_bad_inj = 0, n_off = 0, n_on = 0, n_seq_bad = 0;

  function automatic bit ga(); return fc_en & fc_mode[3]; endfunction
  function automatic bit gb(); return fc_en & fc_mode[2] & !spec_det_en; endfunction
  function automatic bit ra(); return fc_en & fc_mode[1]; endfunction
  function automatic bit rb(); return fc_en & fc_mode[0] & !spec_det_en; endfunction

  function automatic bit m_off(); return rx_vld && ((ra() && rx_byte == chr_off_a) || (rb() && rx_byte == chr_off_b)); endfunction
  function automatic bit m_on();  return rx_vld && ((ra() && rx_byte == chr_on_a)  || (rb() && rx_byte == chr_on_b));  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete(); xs = 0; pend = 0; hold = 0;
    end else begin
      if (q.size() > 0) begin
        if (inj_ack) begin
          if (q[0] == chr_off_a || q[0] == chr_off_b) n_off++; else n_on++;
          if (q[0] == chr_off_b) n_offb++;
          void'(q.pop_front());
        end
      end else if (!xs && fifo_lvl >= lvl_hi && (ga() || gb())) begin
        if (ga()) q.push_back(chr_off_a);
        if (gb()) q.push_back(chr_off_b);
        xs = 1;
      end else if (xs && fifo_lvl <= lvl_lo && (ga() || gb())) begin
        if (ga()) q.push_back(chr_on_a);
        if (gb()) q.push_back(chr_on_b);
        xs = 0;
      end
      if (!tx_busy) hold = pend && (ra() || rb());
      if (m_off()) pend = 1; else if (m_on()) pend = 0;
    end
  end

  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (cyc > 1) begin
      // R1/R8 injection stream, R9 forwarding, R3/R4 hold
      chk(inj_req == (q.size() > 0), "R1/R8 inj_req", inj_req, q.size() > 0);
      if (q.size() > 0) chk(inj_chr == q[0], "R1/R8 inj_chr", inj_chr, q[0]);
      chk(rx_fwd_vld == (rx_vld && !m_off() && !m_on()), "R9 rx_fwd_vld", rx_fwd_vld, rx_vld && !m_off() && !m_on());
      if (rx_fwd_vld) chk(rx_fwd_byte == rx_byte, "R9 rx_fwd_byte", rx_fwd_byte, rx_byte);
      chk(tx_hold == hold, "R3/R4 tx_hold", tx_hold, hold);
      if (inj_req && (!fc_en || fc_mode == 0)) n_bad_inj++;
      if (inj_req && spec_det_en && (inj_chr == chr_off_b || inj_chr == chr_on_b)) n_bad_inj++;
      if (n_on > n_off) n_seq_bad++;
      if (tx_hold && fc_mode[1:0] == 2'b01 && !spec_det_en) n_holdb++;
    end
  end

  initial begin : wd
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [7:0] pick_byte();
    case ($urandom % 6)
      0: return chr_on_a;
      1: return chr_off_a;
      2: return chr_on_b;
      3: return chr_off_b;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(7));
    for (int cfg = 0; cfg < 64; cfg++) begin
      @(negedge clk);
      rst_n = 0; rx_vld = 0; inj_ack = 0; tx_busy = 0;
      fc_mode = cfg[3:0]; fc_en = cfg[4]; spec_det_en = cfg[5];
      @(negedge clk);
      rst_n = 1;
      #(CLK_PERIOD/4);
      // R10 reset state
      chk(!inj_req && !tx_hold, "R10 reset", {inj_req, tx_hold}, 0);
      n_off = 0; n_on = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        fifo_lvl = LVL_W'((i % 64) < 32 ? (i % 64) : 63 - (i % 64));
        rx_vld = ($urandom % 3) == 0;
        rx_byte = pick_byte();
        inj_ack = $urandom % 2;
        tx_busy = ($urandom % 4) != 0;
      end
    end
    @(negedge clk); rx_vld = 0;
    #(CLK_PERIOD/4);
    // R1 pair-B stop characters seen after pair A
    chk(n_offb > 0, "R1 pair B generated", n_offb, 1);
    // R2 pause raised by pair-B recognition alone
    chk(n_holdb > 0, "R2 pair B recognised", n_holdb, 1);
    // R5 and R6 no injection when disabled or pair B reserved
    chk(n_bad_inj == 0, "R5/R6 forbidden injection", n_bad_inj, 0);
    // R7 resume never outnumbers stop
    chk(n_seq_bad == 0, "R7 resume ordering", n_seq_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule